// File: doc/BRIEF.md
# Serial Register Write Decoder

This block receives 16-bit command words over a three-wire serial link (serial clock, serial data and an active-low frame select) and turns each complete word into a register write. The targets are a control register, two 28-bit frequency registers and two 12-bit phase registers. A waveform core reads their contents and the decoded control fields directly from the block's outputs.

The serial inputs are asynchronous to the system clock. The block synchronises them and then detects falling edges of the serial clock. A word is applied only after the frame select returns high, and only if exactly sixteen bits were shifted during that frame.

A frequency register can be written in either of two ways. In paired mode, two consecutive frequency words first fill the low 14 bits and then the high 14 bits. In single-half mode, each frequency word updates one half, and a control bit chooses which half.

Top module: `serial_reg_decoder`

## Requirements
- R1: Data is sampled on each falling edge of `sclk` while `fsync_n` is low, most significant bit first. The serial clock idles high. A 16-bit word takes effect within 8 system clock cycles after `fsync_n` rises.
- R2: A frame that shifts fewer or more than 16 bits changes no register and no output. Falling edges of `sclk` while `fsync_n` is high are ignored. Discarded frames do not advance the paired-write sequence.
- R3: Word bits 15:14 select the target: 00 is the control register, 01 is frequency register 0, 10 is frequency register 1 and 11 is a phase register. A write changes only the register it selects.
- R4: In a phase word, bit 13 selects phase register 0 (value 0) or phase register 1 (value 1). Bit 12 is ignored. Bits 11:0 are the value that is loaded.
- R5: When control bit 13 is 1 (paired mode), frequency words alternate: the first loads bits 13:0 of the addressed register from word bits 13:0, and the next loads bits 27:14. Every control write restarts the sequence at the low half.
- R6: When control bit 13 is 0, each frequency word loads one half, chosen by control bit 12: 0 selects bits 13:0 and 1 selects bits 27:14. The other half keeps its value.
- R7: A control write updates these outputs from the listed word bits: `freq_pair_mode` from bit 13, `freq_hi_half` from 12, `sel_freq` from 11, `sel_phase` from 10, `core_reset` from 8, `clk_off` from 7, `dac_sleep` from 6, `square_en` from 5, `square_full` from 3 and `tri_sel` from 1. Bits 9, 4, 2 and 0 are not stored.
- R8: While `rst_n` is low, every register output is zero and the paired sequence is set to expect the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idles high |
| sdata | input | 1 | Serial data, MSB first |
| fsync_n | input | 1 | Active-low frame select |
| freq0 | output | 28 | Frequency register 0 |
| freq1 | output | 28 | Frequency register 1 |
| phase0 | output | 12 | Phase register 0 |
| phase1 | output | 12 | Phase register 1 |
| sel_freq | output | 1 | Frequency register select |
| sel_phase | output | 1 | Phase register select |
| freq_pair_mode | output | 1 | Paired frequency write mode |
| freq_hi_half | output | 1 | Half chosen in single-half mode |
| core_reset | output | 1 | Reset request to the core |
| clk_off | output | 1 | Internal clock disable |
| dac_sleep | output | 1 | DAC sleep request |
| square_en | output | 1 | Square output enable |
| square_full | output | 1 | Full-rate square (0 = half rate) |
| tri_sel | output | 1 | Triangle (1) or sine (0) |

## Verification
The assertions assume that `sdata` settles no later than the matching falling edge of `sclk`, and that each serial clock level and each frame-select level lasts several system clock cycles. The synchroniser cannot resolve shorter pulses, so a faster link would lose or misorder bits. The stimulus changes `sdata` at the same instant that `sclk` falls and holds every serial level for four system cycles. It also leaves at least eight cycles between frames, so a word is always committed before the next frame begins.

// File: rtl/serial_reg_decoder.sv
module serial_reg_decoder #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        sdata,
  input  logic        fsync_n,
  output logic [27:0] freq0,
  output logic [27:0] freq1,
  output logic [11:0] phase0,
  output logic [11:0] phase1,
  output logic        sel_freq,
  output logic        sel_phase,
  output logic        freq_pair_mode,
  output logic        freq_hi_half,
  output logic        core_reset,
  output logic        clk_off,
  output logic        dac_sleep,
  output logic        square_en,
  output logic        square_full,
  output logic        tri_sel
);
  localparam int WORD_W  = 16;
  localparam int FREQ_W  = 28;
  localparam int HALF_W  = FREQ_W / 2;
  localparam int PHASE_W = 12;
  localparam int CNT_W   = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [SYNC_STAGES-1:0] sclk_q, sdat_q, fs_q;
  logic sclk_prev, fs_prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q    <= '1;
      sdat_q    <= '0;
      fs_q      <= '1;
      sclk_prev <= 1'b1;
      fs_prev   <= 1'b1;
    end else begin
      sclk_q    <= {sclk_q[SYNC_STAGES-2:0], sclk};
      sdat_q    <= {sdat_q[SYNC_STAGES-2:0], sdata};
      fs_q      <= {fs_q[SYNC_STAGES-2:0], fsync_n};
      sclk_prev <= sclk_q[SYNC_STAGES-1];
      fs_prev   <= fs_q[SYNC_STAGES-1];
    end

  wire sclk_s    = sclk_q[SYNC_STAGES-1];
  wire fs_s      = fs_q[SYNC_STAGES-1];
  wire sdat_s    = sdat_q[SYNC_STAGES-1];
  wire sclk_fall = sclk_prev & ~sclk_s;
  wire fs_rise   = ~fs_prev & fs_s;

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (fs_s) begin
      bit_cnt <= '0;
    end else if (sclk_fall) begin
      shreg <= {shreg[WORD_W-2:0], sdat_s};
      if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
    end

  wire commit = fs_rise && (bit_cnt == CNT_FULL);

  wire [1:0]        addr     = shreg[15:14];
  wire              fidx     = shreg[15];
  wire [HALF_W-1:0] fdata    = shreg[HALF_W-1:0];
  wire [PHASE_W-1:0] pdata   = shreg[PHASE_W-1:0];

  logic [FREQ_W-1:0]  freq_r  [2];
  logic [PHASE_W-1:0] phase_r [2];
  logic pend_hi;

  wire hi_half = freq_pair_mode ? pend_hi : freq_hi_half;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      freq_r[0]      <= '0;
      freq_r[1]      <= '0;
      phase_r[0]     <= '0;
      phase_r[1]     <= '0;
      pend_hi        <= 1'b0;
      freq_pair_mode <= 1'b0;
      freq_hi_half   <= 1'b0;
      sel_freq       <= 1'b0;
      sel_phase      <= 1'b0;
      core_reset     <= 1'b0;
      clk_off        <= 1'b0;
      dac_sleep      <= 1'b0;
      square_en      <= 1'b0;
      square_full    <= 1'b0;
      tri_sel        <= 1'b0;
    end else if (commit) begin
      case (addr)
        2'b00: begin
          freq_pair_mode <= shreg[13];
          freq_hi_half   <= shreg[12];
          sel_freq       <= shreg[11];
          sel_phase      <= shreg[10];
          core_reset     <= shreg[8];
          clk_off        <= shreg[7];
          dac_sleep      <= shreg[6];
          square_en      <= shreg[5];
          square_full    <= shreg[3];
          tri_sel        <= shreg[1];
          pend_hi        <= 1'b0;
        end
        2'b11: phase_r[shreg[13]] <= pdata;
        default: begin
          if (hi_half) freq_r[fidx][FREQ_W-1:HALF_W] <= fdata;
          else         freq_r[fidx][HALF_W-1:0]      <= fdata;
          if (freq_pair_mode) pend_hi <= ~pend_hi;
        end
      endcase
    end

  assign freq0  = freq_r[0];
  assign freq1  = freq_r[1];
  assign phase0 = phase_r[0];
  assign phase1 = phase_r[1];
endmodule

module serial_reg_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        commit,
  input logic [15:0] word,
  input logic [4:0]  bit_cnt,
  input logic [27:0] freq0,
  input logic [27:0] freq1,
  input logic [11:0] phase0,
  input logic [11:0] phase1,
  input logic        sel_freq,
  input logic        core_reset,
  input logic        tri_sel
);
  // R2
  no_write_without_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(freq0) && $stable(freq1) && $stable(phase0) && $stable(phase1));
  // R3
  ctrl_leaves_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && word[15:14] == 2'b00 |=> $stable(freq0) && $stable(freq1) && $stable(phase0));
  // R4
  phase0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && word[15:13] == 3'b110 |=> phase0 == $past(word[11:0]) && $stable(phase1));
  // R7
  ctrl_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && word[15:14] == 2'b00 |=> sel_freq == $past(word[11]) &&
      core_reset == $past(word[8]) && tri_sel == $past(word[1]));
  // R2
  bit_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 5'd17);
endmodule

bind serial_reg_decoder serial_reg_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .word(shreg), .bit_cnt(bit_cnt),
  .freq0(freq0), .freq1(freq1), .phase0(phase0), .phase1(phase1),
  .sel_freq(sel_freq), .core_reset(core_reset), .tri_sel(tri_sel)
);

// File: tb/serial_reg_decoder_test.sv
module serial_reg_decoder_test;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, sdata = 1'b0, fsync_n = 1'b1;
  logic [27:0] freq0, freq1;
  logic [11:0] phase0, phase1;
  logic sel_freq, sel_phase, freq_pair_mode, freq_hi_half, core_reset;
  logic clk_off, dac_sleep, square_en, square_full, tri_sel;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_reg_decoder uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .fsync_n(fsync_n),
    .freq0(freq0), .freq1(freq1), .phase0(phase0), .phase1(phase1),
    .sel_freq(sel_freq), .sel_phase(sel_phase), .freq_pair_mode(freq_pair_mode),
    .freq_hi_half(freq_hi_half), .core_reset(core_reset), .clk_off(clk_off),
    .dac_sleep(dac_sleep), .square_en(square_en), .square_full(square_full),
    .tri_sel(tri_sel));

  // {word, target (0 f0, 1 f1, 2 p0, 3 p1, 4 ctrl pack), expected}
  localparam int NV = 17;
  localparam logic [46:0] VEC [NV] = '{
    {16'h2100, 3'd4, 28'h0000220},  // R7 paired mode, reset on
    {16'h5893, 3'd0, 28'h0001893},  // R5 low half first
    {16'h4010, 3'd0, 28'h0041893},  // R5 then high half
    {16'hBFFF, 3'd1, 28'h0003FFF},  // R3 R5 freq1 low
    {16'h8ABC, 3'd1, 28'h2AF3FFF},  // R5 freq1 high
    {16'hC123, 3'd2, 28'h0000123},  // R4 phase0
    {16'hFFED, 3'd3, 28'h0000FED},  // R4 phase1, bit12 ignored
    {16'h1CEA, 3'd4, 28'h00001DF},  // R7 all fields, single-half hi
    {16'h6AAA, 3'd0, 28'hAAA9893},  // R6 high half only
    {16'h7FFF, 3'd0, 28'hFFFD893},  // R6 high again, no toggling
    {16'h0000, 3'd4, 28'h0000000},  // R7 clear
    {16'h8001, 3'd1, 28'h2AF0001},  // R6 low half only
    {16'h2000, 3'd4, 28'h0000200},  // R7 paired mode
    {16'h4005, 3'd0, 28'hFFFC005},  // R5 low
    {16'h2000, 3'd4, 28'h0000200},  // R5 control write restarts
    {16'h4007, 3'd0, 28'hFFFC007},  // R5 low again after restart
    {16'h8003, 3'd1, 28'h000C001}   // R5 high half, other register
  };

  function automatic logic [27:0] ctrl_pack();
    return {18'd0, freq_pair_mode, freq_hi_half, sel_freq, sel_phase, core_reset,
            clk_off, dac_sleep, square_en, square_full, tri_sel};
  endfunction

  function automatic logic [27:0] observe(input logic [2:0] t);
    case (t)
      3'd0: return freq0;
      3'd1: return freq1;
      3'd2: return {16'd0, phase0};
      3'd3: return {16'd0, phase1};
      default: return ctrl_pack();
    endcase
  endfunction

  task automatic check(input string req, input logic [27:0] got, input logic [27:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] val, input int n);
    fsync_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < n; i++) begin
      sdata = val[n-1-i];
      sclk  = 1'b0;
      wait_clk(4);
      sclk  = 1'b1;
      wait_clk(4);
    end
    fsync_n = 1'b1;
    wait_clk(8);
  endtask

  initial begin
    wait_clk(3);
    check("R8 reset freq0", freq0, 28'd0);
    check("R8 reset ctrl", ctrl_pack(), 28'd0);
    rst_n = 1'b1;
    wait_clk(3);
    for (int v = 0; v < NV; v++) begin
      send({16'd0, VEC[v][46:31]}, 16);
      check($sformatf("R1 R3 vector %0d", v), observe(VEC[v][30:28]), VEC[v][27:0]);
    end
    // R2 short frame discarded
    send(32'h0000004F, 8);
    check("R2 short frame", freq0, 28'hFFFC007);
    // R2 long frame discarded, even though its last 16 bits form a valid word
    send(32'h00004123, 17);
    check("R2 long frame", freq0, 28'hFFFC007);
    // R2 sclk edges with fsync_n high ignored
    for (int i = 0; i < 16; i++) begin
      sdata = 1'b1; sclk = 1'b0; wait_clk(4); sclk = 1'b1; wait_clk(4);
    end
    wait_clk(8);
    check("R2 idle clocks", freq1, 28'h000C001);
    // R2 R5 discarded frames did not advance the pair: next word is the low half
    send(32'h00004009, 16);
    check("R5 pair sequence kept", freq0, 28'hFFFC009);
    check("R3 freq1 untouched", freq1, 28'h000C001);
    // R1 no update before the frame closes
    fsync_n = 1'b0; wait_clk(4);
    for (int i = 0; i < 16; i++) begin
      sdata = (16'hC3FF >> (15 - i)) & 1'b1;
      sclk = 1'b0; wait_clk(4); sclk = 1'b1; wait_clk(4);
    end
    wait_clk(8);
    check("R1 held until frame end", {16'd0, phase0}, 28'h123);
    fsync_n = 1'b1; wait_clk(8);
    check("R1 applied at frame end", {16'd0, phase0}, 28'h3FF);
    // R8 reset mid-run
    rst_n = 1'b0; wait_clk(2);
    check("R8 reset freq0", freq0, 28'd0);
    check("R8 reset phase0", {16'd0, phase0}, 28'd0);
    rst_n = 1'b1; wait_clk(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_clk(150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule